// File: doc/BRIEF.md
# Hardware Cursor Overlay Pixel Mux

This block is one stage of a display scan-out path. Each cycle it may accept one pixel: the raster coordinate of that pixel and the 8-bit colour index fetched for it from video memory. Two cycles later it presents the 24-bit RGB value to be shown. Ordinary pixels are translated through a 256-entry colour palette. Where the pixel falls inside a 64x64 hardware cursor, a two-bit code taken from a cursor pattern either lets the background show through or replaces it with one of three cursor colours. A control word can switch the cursor off or force the whole picture to black.

The pattern memory and the colour palette live in the register block and are reached through two synchronous read ports. An address driven in one cycle returns its data in the next. The three cursor colours are static registers and arrive as one flat bus. Raster counting, the video memory fetch and sync generation belong to neighbouring stages. A valid flag travels with each pixel, so the stage accepts gaps in the pixel stream.

Top module: `cursor_overlay_mux`

## Requirements
- R1: After reset `out_valid` is 0 and `out_rgb` is 0.
- R2: A pixel accepted with `in_valid` high at one rising edge appears with `out_valid` high exactly two rising edges later, in input order.
- R3: A pixel outside the cursor, with no blanking, is shown as the colour palette entry at its index, read through `pal_raddr`/`pal_rdata` (red in bits 23:16, green 15:8, blue 7:0).
- R4: The cursor origin is cx = `cur_pos[23:12]` and cy = `cur_pos[11:0]`. A pixel is inside the cursor when cx <= x <= cx+63 and cy <= y <= cy+63.
- R5: For a pixel inside the cursor, the pattern word read is number (y-cy)*8 + (x-cx)/8. Its code is the two bits starting at bit 2*((x-cx) mod 8).
- R6: Code 0 shows the colour palette entry for the pixel's index. Codes 1, 2 and 3 show cursor colour 0, 1 and 2, with colour k at `cur_pal[24k+23:24k]`.
- R7: When `ctrl` bit 23 is 1, no pixel is treated as inside the cursor, and every unblanked pixel shows its colour palette entry.
- R8: When `ctrl` bit 10 is 1, the pixel is output as 0 (black), whatever the cursor or palette hold.
- R9: The containment test does not wrap at the coordinate limits. A cursor whose origin lies near 4095 covers only pixels at or beyond that origin, never pixels near 0.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index from video memory |
| ctrl | input | 32 | Control word; bit 10 blank, bit 23 cursor off |
| cur_pos | input | 24 | Cursor origin, x in 23:12, y in 11:0 |
| cur_pal | input | 72 | Three cursor colours, colour k in bits 24k+23:24k |
| pat_raddr | output | 9 | Cursor pattern word address |
| pat_rdata | input | 16 | Pattern word, one cycle after its address |
| pal_raddr | output | 8 | Colour palette address |
| pal_rdata | input | 24 | Palette entry, one cycle after its address |
| out_valid | output | 1 | `out_rgb` carries a pixel |
| out_rgb | output | 24 | Pixel colour, red in 23:16 |

## Verification
The hardest case to reach is a cursor that hangs past the right or bottom coordinate limit. A design that wraps its subtraction would then paint cursor codes onto pixels near column 0 or row 0. The stimulus places the origin at column 4090 and row 4080, then scans pixels at both the far and the near ends of those rows and columns. Full row sweeps across the cursor at its first, last and just-outside rows cross every word and code boundary. Bubbles are inserted so that valid and idle cycles interleave in the pipeline.

// File: rtl/cur_ovl_pkg.sv
package cur_ovl_pkg;

    // Two-bit cursor code held in the pattern memory
    typedef enum logic [1:0] {
        CODE_CLEAR = 2'd0,
        CODE_COL0  = 2'd1,
        CODE_COL1  = 2'd2,
        CODE_COL2  = 2'd3
    } cur_code_e;

    localparam int unsigned CPAL_N = 3;

endpackage

// File: rtl/cur_hit_calc.sv
module cur_hit_calc #(
    parameter int unsigned COORD_W = 12,
    parameter int unsigned CUR_DIM = 64,
    parameter int unsigned WORD_W  = 16,
    localparam int unsigned DIM_LG = $clog2(CUR_DIM),
    localparam int unsigned SEL_W  = $clog2(WORD_W / 2),
    localparam int unsigned ADDR_W = DIM_LG + DIM_LG - SEL_W
) (
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  logic [2*COORD_W-1:0] pos,
    input  logic                 cur_off,
    output logic                 hit,
    output logic [ADDR_W-1:0]    pat_addr,
    output logic [SEL_W-1:0]     sel
);
    localparam int unsigned SW = COORD_W + 1;
    localparam logic signed [SW-1:0] DIM_S = SW'(CUR_DIM);

    logic [COORD_W-1:0]   cx, cy;
    logic signed [SW-1:0] dx, dy;
    logic                 in_x, in_y;

    assign cx = pos[2*COORD_W-1:COORD_W];
    assign cy = pos[COORD_W-1:0];

    // one extra sign bit keeps a negative offset from wrapping into range
    assign dx = $signed({1'b0, x}) - $signed({1'b0, cx});
    assign dy = $signed({1'b0, y}) - $signed({1'b0, cy});

    assign in_x = !dx[SW-1] && (dx < DIM_S);
    assign in_y = !dy[SW-1] && (dy < DIM_S);
    assign hit  = in_x && in_y && !cur_off;

    assign pat_addr = {dy[DIM_LG-1:0], dx[DIM_LG-1:SEL_W]};
    assign sel      = dx[SEL_W-1:0];

endmodule

// File: rtl/cur_code_pick.sv
module cur_code_pick
    import cur_ovl_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned SEL_W = $clog2(WORD_W / 2)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output cur_code_e         code
);
    assign code = cur_code_e'(word[{sel, 1'b0} +: 2]);
endmodule

// File: rtl/cur_color_sel.sv
module cur_color_sel
    import cur_ovl_pkg::*;
#(
    parameter int unsigned RGB_W = 24
) (
    input  logic                    blank,
    input  logic                    hit,
    input  cur_code_e               code,
    input  logic [RGB_W-1:0]        pal_rgb,
    input  logic [CPAL_N*RGB_W-1:0] cur_pal,
    output logic [RGB_W-1:0]        rgb
);
    logic [RGB_W-1:0] cpal [CPAL_N];

    for (genvar k = 0; k < CPAL_N; k++) begin : g_cpal
        assign cpal[k] = cur_pal[k*RGB_W +: RGB_W];
    end

    always_comb begin
        rgb = pal_rgb;
        if (blank) begin
            rgb = '0;
        end else if (hit) begin
            unique case (code)
                CODE_CLEAR: rgb = pal_rgb;
                CODE_COL0:  rgb = cpal[0];
                CODE_COL1:  rgb = cpal[1];
                CODE_COL2:  rgb = cpal[2];
            endcase
        end
    end
endmodule

// File: rtl/cursor_overlay_mux.sv
module cursor_overlay_mux
    import cur_ovl_pkg::*;
#(
    parameter int unsigned COORD_W     = 12,
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned RGB_W       = 24,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned CUR_DIM     = 64,
    parameter int unsigned CTRL_W      = 32,
    parameter int unsigned BLANK_BIT   = 10,
    parameter int unsigned CUR_OFF_BIT = 23,
    localparam int unsigned DIM_LG     = $clog2(CUR_DIM),
    localparam int unsigned SEL_W      = $clog2(WORD_W / 2),
    localparam int unsigned PADDR_W    = DIM_LG + DIM_LG - SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [COORD_W-1:0]      in_x,
    input  logic [COORD_W-1:0]      in_y,
    input  logic [IDX_W-1:0]        in_index,
    input  logic [CTRL_W-1:0]       ctrl,
    input  logic [2*COORD_W-1:0]    cur_pos,
    input  logic [CPAL_N*RGB_W-1:0] cur_pal,
    output logic [PADDR_W-1:0]      pat_raddr,
    input  logic [WORD_W-1:0]       pat_rdata,
    output logic [IDX_W-1:0]        pal_raddr,
    input  logic [RGB_W-1:0]        pal_rdata,
    output logic                    out_valid,
    output logic [RGB_W-1:0]        out_rgb
);
    logic             unused_ctrl;
    logic             hit0;
    logic [SEL_W-1:0] sel0;

    // stage-one state, aligned with the read-port data
    logic             s1_valid;
    logic             s1_hit;
    logic             s1_blank;
    logic [SEL_W-1:0] s1_sel;

    cur_code_e        s1_code;
    logic [RGB_W-1:0] s1_rgb;

    assign unused_ctrl = ^ctrl;

    cur_hit_calc #(
        .COORD_W (COORD_W),
        .CUR_DIM (CUR_DIM),
        .WORD_W  (WORD_W)
    ) hit_i (
        .x        (in_x),
        .y        (in_y),
        .pos      (cur_pos),
        .cur_off  (ctrl[CUR_OFF_BIT]),
        .hit      (hit0),
        .pat_addr (pat_raddr),
        .sel      (sel0)
    );

    assign pal_raddr = in_index;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_blank <= 1'b0;
            s1_sel   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_hit   <= hit0;
            s1_blank <= ctrl[BLANK_BIT];
            s1_sel   <= sel0;
        end
    end

    cur_code_pick #(
        .WORD_W (WORD_W)
    ) pick_i (
        .word (pat_rdata),
        .sel  (s1_sel),
        .code (s1_code)
    );

    cur_color_sel #(
        .RGB_W (RGB_W)
    ) csel_i (
        .blank   (s1_blank),
        .hit     (s1_hit),
        .code    (s1_code),
        .pal_rgb (pal_rdata),
        .cur_pal (cur_pal),
        .rgb     (s1_rgb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_rgb <= s1_rgb;
            end
        end
    end

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid); // R2

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid); // R10

    AST_CUR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[CUR_OFF_BIT]) |=> !s1_hit); // R7

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_blank) |=> (out_rgb == '0)); // R8

    AST_BG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_blank && !s1_hit) |=> (out_rgb == $past(pal_rdata))); // R3

    AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_blank && s1_hit && s1_code == CODE_CLEAR)
        |=> (out_rgb == $past(pal_rdata))); // R6

endmodule

// File: tb/cursor_overlay_mux_tb.sv
module cursor_overlay_mux_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [7:0]  in_index = '0;
    logic [31:0] ctrl = '0;
    logic [23:0] cur_pos = '0;
    logic [71:0] cur_pal;
    logic [8:0]  pat_raddr;
    logic [15:0] pat_rdata = '0;
    logic [7:0]  pal_raddr;
    logic [23:0] pal_rdata = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    logic [15:0] pat_mem [512];
    logic [23:0] pal_mem [256];
    logic [23:0] cpal_arr [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          qv [$];
    logic [23:0] qr [$];
    string       qt [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // register block model: synchronous read ports
    always_ff @(posedge clk) begin
        pat_rdata <= pat_mem[pat_raddr];
        pal_rdata <= pal_mem[pal_raddr];
    end

    assign cur_pal = {cpal_arr[2], cpal_arr[1], cpal_arr[0]};

    cursor_overlay_mux dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_index  (in_index),
        .ctrl      (ctrl),
        .cur_pos   (cur_pos),
        .cur_pal   (cur_pal),
        .pat_raddr (pat_raddr),
        .pat_rdata (pat_rdata),
        .pal_raddr (pal_raddr),
        .pal_rdata (pal_rdata),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

    function automatic logic [23:0] ref_rgb(int x, int y, int idx,
                                            logic [31:0] c, logic [23:0] p);
        int cx, cy, dx, dy, w, code;
        cx = int'(p[23:12]);
        cy = int'(p[11:0]);
        if (c[10]) return 24'h0;
        if (!c[23] && x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin
            dx = x - cx;
            dy = y - cy;
            w = int'(pat_mem[dy*8 + dx/8]);
            code = (w >> ((dx % 8) * 2)) & 3;
            if (code != 0) return cpal_arr[code-1];
        end
        return pal_mem[idx];
    endfunction

    task automatic compare_front();
        bit          ev;
        logic [23:0] er;
        string       et;
        ev = qv.pop_front();
        er = qr.pop_front();
        et = qt.pop_front();
        checks++;
        if (out_valid !== ev) begin
            fails++;
            $display("FAIL %s: out_valid=%0b expected %0b", et, out_valid, ev);
        end else if (ev && out_rgb !== er) begin
            fails++;
            $display("FAIL %s: out_rgb=%06h expected %06h", et, out_rgb, er);
        end
    endtask

    task automatic step(bit v, int x, int y, int idx, logic [31:0] c,
                        logic [23:0] p, string tag);
        @(negedge clk);
        if (qv.size() == 2) compare_front();
        in_valid = v;
        in_x     = 12'(x);
        in_y     = 12'(y);
        in_index = 8'(idx);
        ctrl     = c;
        cur_pos  = p;
        qv.push_back(v);
        qr.push_back(ref_rgb(x, y, idx, c, p));
        qt.push_back(tag);
    endtask

    task automatic flush();
        step(1'b0, 0, 0, 0, 32'h0, 24'h0, "R10");
        step(1'b0, 0, 0, 0, 32'h0, 24'h0, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] pos;
        for (int i = 0; i < 512; i++) pat_mem[i] = 16'((i * 40503) ^ 16'h5A3C);
        pat_mem[7*8+1] = 16'h0000;
        for (int i = 0; i < 256; i++) pal_mem[i] = {8'(i), 8'(~i), 8'(i ^ 8'h3C)};
        cpal_arr[0] = 24'hFF0000;
        cpal_arr[1] = 24'h00FF00;
        cpal_arr[2] = 24'h0000FF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
            fails++;
            $display("FAIL R1: valid=%0b rgb=%06h expected 0 and 000000", out_valid, out_rgb);
        end
        rst_n = 1'b1;

        pos = {12'd100, 12'd50};
        // R3: background far from the cursor
        for (int i = 0; i < 20; i++) step(1'b1, 300 + i, 400, i * 13, 32'h0, pos, "R3");
        // R4 R5 R6: sweeps across edges and word boundaries
        for (int x = 96; x <= 166; x++) step(1'b1, x, 49,  x, 32'h0, pos, "R4");
        for (int x = 96; x <= 166; x++) step(1'b1, x, 50,  x, 32'h0, pos, "R4");
        for (int x = 96; x <= 166; x++) step(1'b1, x, 57,  x, 32'h0, pos, "R5");
        for (int x = 96; x <= 166; x++) step(1'b1, x, 113, x, 32'h0, pos, "R4");
        for (int x = 96; x <= 166; x++) step(1'b1, x, 114, x, 32'h0, pos, "R4");
        for (int x = 108; x < 116; x++) step(1'b1, x, 57, x + 1, 32'h0, pos, "R6");
        // R2: bubbles interleaved
        for (int i = 0; i < 30; i++)
            step(i % 3 != 1, 100 + i, 60, i, 32'h0, pos, "R2");
        flush();
        // R7: cursor disabled
        for (int x = 96; x <= 166; x++) step(1'b1, x, 70, x, 32'h0080_0000, pos, "R7");
        // R8: forced blank, with and without cursor
        for (int x = 96; x <= 130; x++) step(1'b1, x, 70, x, 32'h0000_0400, pos, "R8");
        for (int x = 96; x <= 110; x++) step(1'b1, x, 70, x, 32'h0080_0400, pos, "R8");
        // R9: cursor hanging over the far coordinate limits
        pos = {12'd4090, 12'd4080};
        for (int x = 0; x < 12; x++)   step(1'b1, x, 4080, x, 32'h0, pos, "R9");
        for (int x = 4084; x < 4096; x++) step(1'b1, x, 4080, x, 32'h0, pos, "R9");
        for (int y = 0; y < 8; y++)    step(1'b1, 4092, y, y, 32'h0, pos, "R9");
        for (int y = 4088; y < 4096; y++) step(1'b1, 4093, y, y, 32'h0, pos, "R9");
        pos = {12'd0, 12'd0};
        for (int x = 0; x < 70; x++)   step(1'b1, x, 63, x, 32'h0, pos, "R5");
        flush();
        // R10: idle stream
        for (int i = 0; i < 6; i++) step(1'b0, i, i, i, 32'h0, pos, "R10");
        flush();
        @(negedge clk);
        while (qv.size() > 0) compare_front();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule